// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a burst that runs inside an already open row. A memory controller can use it to drive the column bus. A self-checking memory model can use it to predict which column each data beat touches. A start strobe captures the start column and the burst configuration. From the next cycle the block presents the first beat. Each cycle with advance high moves it to the next beat.

Fixed-length bursts stay inside an aligned block whose size equals the burst length. The offset within that block either counts up and wraps, or is formed by XOR of the start offset with the beat number. A full-page burst walks through all 256 columns in ascending order and wraps around. It ends only on a terminate strobe. A write-single option turns every write into a one-beat access and leaves reads at the programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `active` and `lastBeat` are low.
- R2: In the cycle after `startStb`, `active` is high and `col` equals the captured `startCol`.
- R3: `blSel` codes are 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8 and 111 = full page. Every other code gives 1 beat. In sequential order (`interleave` = 0), beat n of a fixed burst of length L keeps the start column bits above log2(L) and sets the low bits to (start + n) mod L.
- R4: In interleaved order (`interleave` = 1), beat n of a fixed burst keeps the upper bits and sets the low bits to the start offset XOR n.
- R5: A 1-beat burst shows its single column with `lastBeat` high.
- R6: `lastBeat` is high exactly on the final beat of a fixed burst. Advance on that beat ends the burst, so `active` is low in the next cycle.
- R7: A full-page burst is always sequential, whatever `interleave` is. It steps from column 255 to column 0 and never raises `lastBeat`.
- R8: `terminate` while active ends any burst, so `active` is low in the next cycle. This holds even when advance is high in the same cycle.
- R9: With `wrSingle` = 1, a write burst (`isWrite` = 1) is one beat long, whatever `blSel` is. A read with `wrSingle` = 1 keeps the programmed length.
- R10: With `wrSingle` = 0, writes use the programmed length, as reads do.
- R11: While active with `advance` low, `col` holds its value and the burst stays active.
- R12: `startStb` during an active burst restarts the block with the new configuration. It takes priority over `terminate` and `advance` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startStb | input | 1 | Capture configuration and begin a burst |
| startCol | input | 8 | Start column of the burst |
| blSel | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| isWrite | input | 1 | The burst being started is a write |
| wrSingle | input | 1 | Writes are single-location accesses |
| advance | input | 1 | Step to the next beat |
| terminate | input | 1 | End the current burst |
| active | output | 1 | A beat is being presented |
| col | output | 8 | Column address of the current beat |
| lastBeat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Three strobes can arrive in the same cycle and have to be resolved by priority. The bench raises terminate together with advance on the final beat of a two-beat burst and requires the burst to end with no further beat. It also raises a new start together with terminate and advance in the middle of an eight-beat burst. In that case the bench requires the next cycle to show the new start column under the new length, and requires the rest of that burst to follow its own wrap rule.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } colStrobes_t;

  localparam logic [2:0] BL_FULL = 3'b111;

  function automatic logic [7:0] lenMask(input logic [2:0] sel);
    case (sel)
      3'b001:  lenMask = 8'd1;
      3'b010:  lenMask = 8'd3;
      3'b011:  lenMask = 8'd7;
      BL_FULL: lenMask = 8'hFF;
      default: lenMask = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobes_t      strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blSel,
  input  logic             interleave,
  input  logic             forceSingle,
  output logic [COL_W-1:0] col,
  output logic             cntAtEnd
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] blkMask;
  logic [COL_W-1:0] beatCnt;
  logic             xorOrder;
  logic [COL_W-1:0] offset;
  logic [7:0]       rawMask;

  assign rawMask = lenMask(blSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol  <= '0;
      blkMask  <= '0;
      beatCnt  <= '0;
      xorOrder <= 1'b0;
    end else if (strobes.load) begin
      baseCol  <= startCol;
      blkMask  <= forceSingle ? '0 : COL_W'(rawMask);
      beatCnt  <= '0;
      xorOrder <= interleave && (blSel != BL_FULL) && !forceSingle;
    end else if (strobes.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  assign offset   = xorOrder ? (baseCol ^ beatCnt) : (baseCol + beatCnt);
  assign col      = (baseCol & ~blkMask) | (offset & blkMask);
  assign cntAtEnd = (beatCnt == blkMask);

endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        advance,
  input  logic        terminate,
  input  logic        fullLoad,
  input  logic        cntAtEnd,
  output colStrobes_t strobes,
  output logic        active,
  output logic        lastBeat
);

  logic fullRun;

  assign lastBeat     = active && !fullRun && cntAtEnd;
  assign strobes.load = startStb;
  assign strobes.step = active && advance && !terminate && !startStb && !lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      fullRun <= 1'b0;
    end else if (startStb) begin
      active  <= 1'b1;
      fullRun <= fullLoad;
    end else if (active && terminate) begin
      active  <= 1'b0;
    end else if (active && advance && lastBeat) begin
      active  <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blSel,
  input  logic             interleave,
  input  logic             isWrite,
  input  logic             wrSingle,
  input  logic             advance,
  input  logic             terminate,
  output logic             active,
  output logic [COL_W-1:0] col,
  output logic             lastBeat
);

  colStrobes_t strobes;
  logic        forceSingle;
  logic        fullLoad;
  logic        cntAtEnd;

  assign forceSingle = isWrite && wrSingle;
  assign fullLoad    = (blSel == BL_FULL) && !forceSingle;

  burst_col_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .advance(advance),
    .terminate(terminate), .fullLoad(fullLoad), .cntAtEnd(cntAtEnd),
    .strobes(strobes), .active(active), .lastBeat(lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startCol(startCol),
    .blSel(blSel), .interleave(interleave), .forceSingle(forceSingle),
    .col(col), .cntAtEnd(cntAtEnd)
  );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startStb,
  input logic [COL_W-1:0] startCol,
  input logic             isWrite,
  input logic             wrSingle,
  input logic             advance,
  input logic             terminate,
  input logic             active,
  input logic [COL_W-1:0] col,
  input logic             lastBeat
);

  // R6
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> active);

  // R2
  start_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (active && col == $past(startCol)));

  // R8
  terminate_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && terminate && !startStb) |=> !active);

  // R6
  last_advance_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && advance && lastBeat && !startStb) |=> !active);

  // R11
  hold_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !advance && !terminate && !startStb) |=> (active && $stable(col)));

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && isWrite && wrSingle) |=> lastBeat);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
  .isWrite(isWrite), .wrSingle(wrSingle), .advance(advance),
  .terminate(terminate), .active(active), .col(col), .lastBeat(lastBeat)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStb = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] blSel = '0;
  logic       interleave = 1'b0;
  logic       isWrite = 1'b0;
  logic       wrSingle = 1'b0;
  logic       advance = 1'b0;
  logic       terminate = 1'b0;
  logic       active;
  logic [7:0] col;
  logic       lastBeat;

  int total = 0;
  int failed = 0;

  always #4 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .blSel(blSel), .interleave(interleave), .isWrite(isWrite),
    .wrSingle(wrSingle), .advance(advance), .terminate(terminate),
    .active(active), .col(col), .lastBeat(lastBeat)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] sel, input bit wr, input bit ws);
    if (wr && ws) return 1;
    case (sel)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] s, input int len, input bit ilv, input int n);
    logic [7:0] m;
    logic [7:0] off;
    m = 8'(len - 1);
    off = ilv ? ((s & m) ^ 8'(n)) : (s + 8'(n));
    return (s & ~m) | (off & m);
  endfunction

  task automatic begin_burst(input logic [7:0] s, input logic [2:0] sel,
                             input bit ilv, input bit wr, input bit ws);
    startStb = 1'b1; startCol = s; blSel = sel; interleave = ilv;
    isWrite = wr; wrSingle = ws;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic run_fixed(input logic [7:0] s, input logic [2:0] sel, input bit ilv,
                           input bit wr, input bit ws, input string tag);
    int len;
    len = lenOf(sel, wr, ws);
    begin_burst(s, sel, ilv, wr, ws);
    for (int n = 0; n < len; n++) begin
      check({tag, " col"}, col, expCol(s, len, ilv, n));
      check({tag, " lastBeat"}, lastBeat, (n == len - 1));
      check({tag, " active"}, active, 1);
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0;
    check({tag, " ended"}, active, 0);
  endtask

  task automatic test_full_page();
    begin_burst(8'hFD, 3'b111, 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 6; n++) begin
      check("R7 full col", col, 8'(8'hFD + n));
      check("R7 full lastBeat", lastBeat, 0);
      advance = 1'b1;
      @(negedge clk);
    end
    check("R7 full col after wrap", col, 8'h03);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0; advance = 1'b0;
    check("R8 full terminate", active, 0);
  endtask

  task automatic test_terminate_mid();
    begin_burst(8'h40, 3'b011, 1'b0, 1'b0, 1'b0);
    advance = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 mid col", col, 8'h43);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0; advance = 1'b0;
    check("R8 mid terminate", active, 0);
    check("R8 mid lastBeat", lastBeat, 0);
  endtask

  task automatic test_hold();
    begin_burst(8'h2A, 3'b011, 1'b0, 1'b0, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check("R11 hold col", col, 8'h2A);
      check("R11 hold active", active, 1);
    end
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R11 step col", col, 8'h2B);
    @(negedge clk);
    check("R11 hold after step", col, 8'h2B);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
  endtask

  task automatic test_restart();
    logic [7:0] exp4 [4];
    exp4 = '{8'h91, 8'h92, 8'h93, 8'h90};
    begin_burst(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
    advance = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 before restart", col, 8'h12);
    startStb = 1'b1; startCol = 8'h91; blSel = 3'b010; terminate = 1'b1;
    @(negedge clk);
    startStb = 1'b0; terminate = 1'b0;
    for (int n = 0; n < 4; n++) begin
      check("R12 restart active", active, 1);
      check("R12 restart col", col, exp4[n]);
      check("R12 restart lastBeat", lastBeat, (n == 3));
      @(negedge clk);
    end
    advance = 1'b0;
    check("R12 restart ended", active, 0);
  endtask

  task automatic test_collision_last();
    begin_burst(8'h07, 3'b001, 1'b0, 1'b0, 1'b0);
    check("R3 L2 beat0", col, 8'h07);
    advance = 1'b1;
    @(negedge clk);
    check("R3 L2 wrap beat", col, 8'h06);
    check("R6 L2 last", lastBeat, 1);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0; advance = 1'b0;
    check("R6 R8 collision ended", active, 0);
    check("R6 R8 collision lastBeat", lastBeat, 0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset active", active, 0);
    check("R1 reset lastBeat", lastBeat, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release active", active, 0);

    run_fixed(8'h35, 3'b001, 1'b0, 1'b0, 1'b0, "R2 R3 seq L2");
    run_fixed(8'h5E, 3'b010, 1'b0, 1'b0, 1'b0, "R3 seq L4");
    run_fixed(8'h7D, 3'b011, 1'b0, 1'b0, 1'b0, "R3 R6 seq L8");
    run_fixed(8'h12, 3'b000, 1'b0, 1'b0, 1'b0, "R5 L1");
    run_fixed(8'h33, 3'b100, 1'b0, 1'b0, 1'b0, "R3 R5 reserved code");
    run_fixed(8'h5E, 3'b010, 1'b1, 1'b0, 1'b0, "R4 ilv L4");
    run_fixed(8'h7D, 3'b011, 1'b1, 1'b0, 1'b0, "R4 ilv L8");
    run_fixed(8'hA6, 3'b011, 1'b0, 1'b1, 1'b1, "R9 single write");
    run_fixed(8'hA6, 3'b010, 1'b0, 1'b0, 1'b1, "R9 read keeps length");
    run_fixed(8'hC5, 3'b010, 1'b1, 1'b1, 1'b0, "R10 write burst");
    test_full_page();
    test_terminate_mid();
    test_hold();
    test_restart();
    test_collision_last();

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule